// File: doc/BRIEF.md
# Stereo PWM Output Mute and Reset Sequencer

This block sits between a stereo PWM modulator and the output pins of a digital audio amplifier front end. Each channel has a differential pair, a positive leg and a negative leg. The block decides when the modulator's pulses reach those pins. It also raises a per-channel flag once the pins carry meaningful data.

The block has three ways to silence the output:

- **Hard silencing** while the active-low reset or the active-low power-down input is asserted. The positive leg is forced low and the negative leg is forced high.
- **Initialization period** after both inputs are released. The hard silencing holds for a parameterized number of clock cycles. This period stands in for a wait of up to 5 ms.
- **Quiet mute** when the active-low mute input is driven low. Both legs of each channel carry the same square wave with 50% duty, which is a zero-valued differential signal.

Quiet mute is entered and left only on a PWM frame boundary, so no pulse is cut short.

Top module: `pwm_out_sequencer`

## Requirements
- R1: While `rst_n` is low, every positive output is 0, every negative output is 1 and both valid flags are 0. This applies from the same instant, with no clock edge needed.
- R2: While `pwdn_n` is low, the outputs take the same hard-silenced values as in R1 and both valid flags are 0. This also applies immediately.
- R3: If `rst_n` rises while `pwdn_n` is still low, the block stays hard-silenced and the valid flags stay 0 for as long as `pwdn_n` stays low.
- R4: Take the first clock edge after both `rst_n` and `pwdn_n` are high as edge 1. The valid flags are 0 after edge `INIT_CYCLES+1` and 1 after edge `INIT_CYCLES+2`. This covers two synchronizer stages and the initialization count.
- R5: After power-down is released, the same initialization latency as in R4 applies again before the valid flags rise.
- R6: With `mute_n` low and the block valid, all four outputs carry one in-phase square wave.
  - Its period is `FRAME_LEN` cycles.
  - It is high for the first `FRAME_LEN/2` cycles of each frame and low for the rest.
- R7: With `mute_n` high and the block valid, each output equals its modulator input in the same cycle.
- R8: Quiet mute starts and ends only at a frame boundary. Every high pulse and every low gap of the zero waveform lasts exactly `FRAME_LEN/2` cycles, including the first pulse and the last pulse.
- R9: The valid flags stay 1 during quiet mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwdn_n | input | 1 | Power-down request, active low |
| mute_n | input | 1 | Quiet-mute request, active low |
| l_pos_in | input | 1 | Left positive-leg PWM from the modulator |
| l_neg_in | input | 1 | Left negative-leg PWM from the modulator |
| r_pos_in | input | 1 | Right positive-leg PWM from the modulator |
| r_neg_in | input | 1 | Right negative-leg PWM from the modulator |
| l_pos_out | output | 1 | Gated left positive leg |
| l_neg_out | output | 1 | Gated left negative leg |
| r_pos_out | output | 1 | Gated right positive leg |
| r_neg_out | output | 1 | Gated right negative leg |
| l_valid | output | 1 | Left output carries valid data or quiet mute |
| r_valid | output | 1 | Right output carries valid data or quiet mute |

## Verification
Some properties are checked on every cycle:
- The hard-silenced pin levels whenever power-down or reset is asserted.
- The valid flags rising only on the cycle after the initialization count completes.
- The in-phase legs while quiet mute is active.
- Passthrough while it is not.
- The internal mute state changing only on the first cycle of a frame.

Other behaviour needs the bench's scenarios to show it:
- The exact latency from release to valid.
- The re-initialization after a power-down cycle.
- The case where reset is released while power-down is held.
- That every zero-waveform pulse seen at the pins, from mute entry to mute exit, is exactly half a frame long.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  typedef enum logic [0:0] {
    SEQ_INIT = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Level of the zero waveform at a given position inside the frame.
  function automatic logic zero_wave_level(input int unsigned pos, input int unsigned frame_len);
    return (pos < (frame_len / 2));
  endfunction

  // True on the last cycle of a frame.
  function automatic logic frame_is_last(input int unsigned pos, input int unsigned frame_len);
    return (pos == (frame_len - 1));
  endfunction

  // True on the final cycle of the initialization count.
  function automatic logic init_is_last(input int unsigned cnt, input int unsigned init_len);
    return (cnt == (init_len - 1));
  endfunction

endpackage

// File: rtl/pwm_release_sync.sv
module pwm_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_n,
  output logic released
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge async_n) begin
    if (!async_n) chain <= '0;
    else          chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign released = chain[STAGES-1];
endmodule

// File: rtl/pwm_init_fsm.sv
module pwm_init_fsm
  import pwm_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 50
) (
  input  logic clk,
  input  logic live_n,
  output logic running,
  output logic init_done
);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  seq_state_e state;
  logic [IW-1:0] cnt;

  assign init_done = (state == SEQ_INIT) && init_is_last(int'(cnt), INIT_CYCLES);
  assign running   = (state == SEQ_RUN);

  always_ff @(posedge clk or negedge live_n) begin
    if (!live_n) begin
      state <= SEQ_INIT;
      cnt   <= '0;
    end else if (state == SEQ_INIT) begin
      if (init_done) state <= SEQ_RUN;
      else           cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_frame_gen.sv
module pwm_frame_gen
  import pwm_seq_pkg::*;
#(
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic live_n,
  input  logic mute_n,
  output logic zero_lvl,
  output logic frame_first,
  output logic mute_act
);
  localparam int FW = $clog2(FRAME_LEN);

  logic [FW-1:0] pos;
  logic [SYNC_STAGES-1:0] mute_sync;
  logic last;

  assign last        = frame_is_last(int'(pos), FRAME_LEN);
  assign frame_first = (pos == '0);
  assign zero_lvl    = zero_wave_level(int'(pos), FRAME_LEN);

  always_ff @(posedge clk or negedge live_n) begin
    if (!live_n) pos <= '0;
    else if (last) pos <= '0;
    else pos <= pos + 1'b1;
  end

  always_ff @(posedge clk or negedge live_n) begin
    if (!live_n) mute_sync <= '1;
    else         mute_sync <= {mute_sync[SYNC_STAGES-2:0], mute_n};
  end

  // The mute state is taken over only at the end of a frame.
  always_ff @(posedge clk or negedge live_n) begin
    if (!live_n) mute_act <= 1'b0;
    else if (last) mute_act <= ~mute_sync[SYNC_STAGES-1];
  end
endmodule

// File: rtl/pwm_out_gate.sv
module pwm_out_gate (
  input  logic hard,
  input  logic quiet,
  input  logic zero_lvl,
  input  logic pos_in,
  input  logic neg_in,
  output logic pos_out,
  output logic neg_out
);
  always_comb begin
    if (hard) begin
      pos_out = 1'b0;
      neg_out = 1'b1;
    end else if (quiet) begin
      pos_out = zero_lvl;
      neg_out = zero_lvl;
    end else begin
      pos_out = pos_in;
      neg_out = neg_in;
    end
  end
endmodule

// File: rtl/pwm_out_sequencer.sv
module pwm_out_sequencer #(
  parameter int FRAME_LEN   = 16,
  parameter int INIT_CYCLES = 50,
  parameter int SYNC_STAGES = 2,
  parameter int CHANNELS    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwdn_n,
  input  logic mute_n,
  input  logic l_pos_in,
  input  logic l_neg_in,
  input  logic r_pos_in,
  input  logic r_neg_in,
  output logic l_pos_out,
  output logic l_neg_out,
  output logic r_pos_out,
  output logic r_neg_out,
  output logic l_valid,
  output logic r_valid
);
  logic [1:0] hold_n;
  logic [1:0] released;
  logic live_n;
  logic running;
  logic init_done;
  logic zero_lvl;
  logic frame_first;
  logic mute_act;
  logic hard_mute;
  logic any_valid;
  logic [CHANNELS-1:0] ch_pos_in, ch_neg_in, ch_pos_out, ch_neg_out;

  assign hold_n = {pwdn_n, rst_n};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    pwm_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .async_n  (hold_n[i]),
      .released (released[i])
    );
  end

  assign live_n = &released;

  pwm_init_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_fsm (
    .clk       (clk),
    .live_n    (live_n),
    .running   (running),
    .init_done (init_done)
  );

  pwm_frame_gen #(.FRAME_LEN(FRAME_LEN), .SYNC_STAGES(SYNC_STAGES)) u_frame (
    .clk         (clk),
    .live_n      (live_n),
    .mute_n      (mute_n),
    .zero_lvl    (zero_lvl),
    .frame_first (frame_first),
    .mute_act    (mute_act)
  );

  // Assertion of reset or power-down acts on the pins without waiting for a clock.
  assign any_valid = running & rst_n & pwdn_n;
  assign hard_mute = ~any_valid;

  assign ch_pos_in = {r_pos_in, l_pos_in};
  assign ch_neg_in = {r_neg_in, l_neg_in};

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    pwm_out_gate u_gate (
      .hard     (hard_mute),
      .quiet    (mute_act),
      .zero_lvl (zero_lvl),
      .pos_in   (ch_pos_in[c]),
      .neg_in   (ch_neg_in[c]),
      .pos_out  (ch_pos_out[c]),
      .neg_out  (ch_neg_out[c])
    );
  end

  assign l_pos_out = ch_pos_out[0];
  assign l_neg_out = ch_neg_out[0];
  assign r_pos_out = ch_pos_out[1];
  assign r_neg_out = ch_neg_out[1];
  assign l_valid   = any_valid;
  assign r_valid   = any_valid;
endmodule

// File: rtl/pwm_seq_checker.sv
module pwm_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic pwdn_n,
  input logic live_n,
  input logic init_done,
  input logic frame_first,
  input logic mute_act,
  input logic l_pos_in,
  input logic l_neg_in,
  input logic l_pos_out,
  input logic l_neg_out,
  input logic r_pos_out,
  input logic r_neg_out,
  input logic l_valid,
  input logic r_valid
);
  // R1: reset forces hard silencing immediately.
  always_comb begin
    if (rst_n === 1'b0) begin
      a_reset_hard_r1: assert (l_pos_out == 1'b0 && l_neg_out == 1'b1 &&
                               r_pos_out == 1'b0 && r_neg_out == 1'b1 &&
                               !l_valid && !r_valid);
    end
  end

  p_pwdn_hard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwdn_n |-> (!l_pos_out && l_neg_out && !r_pos_out && r_neg_out && !l_valid && !r_valid));

  p_valid_after_init_r4: assert property (@(posedge clk) disable iff (!live_n)
    $rose(l_valid) |-> $past(init_done));

  p_quiet_inphase_r6: assert property (@(posedge clk) disable iff (!live_n)
    (l_valid && mute_act) |-> (l_pos_out == l_neg_out && l_pos_out == r_pos_out && r_pos_out == r_neg_out));

  p_passthrough_r7: assert property (@(posedge clk) disable iff (!live_n)
    (l_valid && !mute_act) |-> (l_pos_out == l_pos_in && l_neg_out == l_neg_in));

  p_mute_on_boundary_r8: assert property (@(posedge clk) disable iff (!live_n)
    (mute_act != $past(mute_act)) |-> frame_first);

  p_valid_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    l_valid == r_valid);
endmodule

bind pwm_out_sequencer pwm_seq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwdn_n      (pwdn_n),
  .live_n      (live_n),
  .init_done   (init_done),
  .frame_first (frame_first),
  .mute_act    (mute_act),
  .l_pos_in    (l_pos_in),
  .l_neg_in    (l_neg_in),
  .l_pos_out   (l_pos_out),
  .l_neg_out   (l_neg_out),
  .r_pos_out   (r_pos_out),
  .r_neg_out   (r_neg_out),
  .l_valid     (l_valid),
  .r_valid     (r_valid)
);

// File: tb/pwm_out_sequencer_test.sv
module pwm_out_sequencer_test;
  localparam int FRAME_LEN   = 16;
  localparam int INIT_CYCLES = 50;
  localparam int HALF        = FRAME_LEN / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwdn_n = 1'b1, mute_n = 1'b1;
  logic l_pos_in = 1'b0, l_neg_in = 1'b0, r_pos_in = 1'b0, r_neg_in = 1'b0;
  logic l_pos_out, l_neg_out, r_pos_out, r_neg_out, l_valid, r_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_out_sequencer #(.FRAME_LEN(FRAME_LEN), .INIT_CYCLES(INIT_CYCLES)) uut (
    .clk(clk), .rst_n(rst_n), .pwdn_n(pwdn_n), .mute_n(mute_n),
    .l_pos_in(l_pos_in), .l_neg_in(l_neg_in), .r_pos_in(r_pos_in), .r_neg_in(r_neg_in),
    .l_pos_out(l_pos_out), .l_neg_out(l_neg_out), .r_pos_out(r_pos_out), .r_neg_out(r_neg_out),
    .l_valid(l_valid), .r_valid(r_valid)
  );

  // Stimulus {lp,ln,rp,rn} and the expected outputs during passthrough.
  localparam logic [7:0] VEC [8] = '{
    8'b0000_0000, 8'b1010_1010, 8'b0101_0101, 8'b1111_1111,
    8'b1001_1001, 8'b0110_0110, 8'b1100_1100, 8'b0011_0011
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] pins();
    return {l_pos_out, l_neg_out, r_pos_out, r_neg_out, l_valid, r_valid};
  endfunction

  localparam logic [5:0] HARD = 6'b01_01_00;

  task automatic set_data(input logic [3:0] d);
    {l_pos_in, l_neg_in, r_pos_in, r_neg_in} = d;
  endtask

  // Release at a negedge, then check the valid latency from R4.
  task automatic check_latency(input string req);
    for (int e = 1; e <= INIT_CYCLES + 2; e++) begin
      @(posedge clk); #1;
      if (e == INIT_CYCLES + 1) check({req, " valid still low"}, l_valid, 1'b0);
      if (e == INIT_CYCLES + 2) check({req, " valid rises"}, {l_valid, r_valid}, 2'b11);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int hi_run, lo_run, bad_run, bad_phase, nruns;
    logic prev;
    bit seen_hi;

    // R1: reset state
    set_data(4'b1010);
    #2;
    check("R1 reset state", pins(), HARD);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_latency("R4");

    // R7: passthrough vector table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      set_data(VEC[i][7:4]);
      #2;
      check("R7 passthrough", {l_pos_out, l_neg_out, r_pos_out, r_neg_out}, VEC[i][3:0]);
    end

    // R6, R8, R9: quiet mute entry and exit
    @(negedge clk);
    set_data(4'b0000);
    mute_n = 1'b0;
    hi_run = 0; lo_run = 0; bad_run = 0; bad_phase = 0; nruns = 0;
    prev = 1'b0; seen_hi = 1'b0;
    for (int c = 0; c < 8 * FRAME_LEN; c++) begin
      if (c == 4 * FRAME_LEN) begin
        @(negedge clk); mute_n = 1'b1;
      end
      @(posedge clk); #1;
      if (!(l_pos_out == l_neg_out && l_pos_out == r_pos_out && r_pos_out == r_neg_out)) bad_phase++;
      if (!l_valid || !r_valid) bad_phase++;
      if (l_pos_out) begin
        if (!prev && seen_hi && lo_run != HALF) bad_run++;
        hi_run++; lo_run = 0; seen_hi = 1'b1;
      end else begin
        if (prev) begin
          if (hi_run != HALF) bad_run++;
          nruns++;
        end
        hi_run = 0; lo_run++;
      end
      prev = l_pos_out;
    end
    check("R6 legs in phase during mute", bad_phase, 0);
    check("R9 valid held through mute", {l_valid, r_valid}, 2'b11);
    check("R8 no truncated pulse or gap", bad_run, 0);
    check("R6 zero wave pulses seen", (nruns >= 3), 1'b1);
    @(negedge clk);
    set_data(4'b1001); #2;
    check("R7 passthrough after unmute", {l_pos_out, l_neg_out, r_pos_out, r_neg_out}, 4'b1001);

    // R2: power-down acts immediately
    @(negedge clk);
    pwdn_n = 1'b0; #1;
    check("R2 power-down hard silence", pins(), HARD);

    // R3: reset released while power-down held
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R1 total power-down", pins(), HARD);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (INIT_CYCLES + 10) @(posedge clk);
    #1;
    check("R3 held by power-down", pins(), HARD);

    // R5: release power-down, re-initialize
    @(negedge clk);
    pwdn_n = 1'b1;
    check_latency("R5");

    // R1: asynchronous reset mid-frame, between clock edges
    @(negedge clk);
    set_data(4'b1010);
    #2;
    rst_n = 1'b0; #1;
    check("R1 async reset in run", pins(), HARD);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule